// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Generator

This block supervises a host processor and drives its active-low, open-drain reset line. One output, `rst_pull_low`, tells the pad to sink the line (1) or release it to the external pull-up (0). Three events pull the line low: the end of the power-on sequence, a supply that a low-voltage comparator flags as below its trip point, and a watchdog period that runs out without service from the host.

The watchdog counts cycles of the 32.768 kHz oscillator. It has three fixed periods: 0.25 s, 0.75 s and 1.5 s, which are 8192, 24576 and 49152 cycles. Any host activity that the serial front end turns into a one-cycle `kick` strobe restarts the count. Each reset, whatever its cause, is stretched to a minimum pulse of `PULSE_CYCLES` (8192 cycles, 0.25 s). The watchdog starts again from zero once the line is released. The low-voltage flag is asynchronous, so it passes through a `SYNC_STAGES`-deep synchronizer before it is used.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_pull_low` reads 1 from the next edge on. After `rst_n` goes high, it stays 1 until the `PULSE_CYCLES`-th rising edge, counting the first edge with `rst_n` high as edge 1, and reads 0 from that edge on.
- R2: `tmo_sel` picks the watchdog period in oscillator cycles: 0 gives `BASE_CYCLES`, 1 gives 3·`BASE_CYCLES`, and 2 or 3 give 6·`BASE_CYCLES`. With the defaults these are 8192, 24576 and 49152 cycles, that is 0.25 s, 0.75 s and 1.5 s.
- R3: With `wdt_en` high and no kick, `rst_pull_low` rises on the L-th edge after the edge that released the reset, where L is the period chosen under R2.
- R4: A `kick` sampled high restarts the period, so `rst_pull_low` rises on the L-th edge after the last kick edge.
- R5: While `wdt_en` is low, the watchdog never asserts reset. When `wdt_en` goes high, the edge that first samples it high counts as the first of the L edges.
- R6: A watchdog reset holds `rst_pull_low` at 1 for exactly `PULSE_CYCLES` edges and then releases it. The next timeout is then a full period measured from that release.
- R7: When `low_volt` goes high, `rst_pull_low` is 1 by edge `SYNC_STAGES`+1, counting the first edge that samples it high as edge 1. It stays 1 while the flag is high. It is released on edge `PULSE_CYCLES`+`SYNC_STAGES`, counting the first edge that samples the flag low as edge 1. A short pulse of the flag during any hold restarts the hold.
- R8: If `tmo_sel` changes to a shorter period while the count has already reached or passed the new limit, reset asserts on the next edge. Otherwise the new limit applies to the count already made.
- R9: A `kick` during a reset hold has no effect on the length of the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| kick | input | 1 | One-cycle watchdog service strobe, synchronous to `clk` |
| tmo_sel | input | 2 | Watchdog period select (encoding in R2) |
| wdt_en | input | 1 | Watchdog enable; low stops and clears the count |
| low_volt | input | 1 | Asynchronous supply-below-trip flag |
| rst_pull_low | output | 1 | 1 = sink the open-drain reset line low |

## Verification
The case hardest to reach from the ports is a change of the period select while the count is already past the new, shorter limit. With a plain equality compare that count would never match again and the watchdog would go silent. The bench sets the longest period, lets 30 cycles pass after a release, and then drops to the shortest period, where the next edge must assert reset. A second case switches after only three cycles and expects the remaining count to be used. To cover period lengths fully, the bench is built with a small base period and sweeps every kick offset inside each of the four select codes. It also pulses the low-voltage flag for one cycle during the power-on hold to show that the hold restarts.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the supervisor reset generator.
// Assumes all counts are in cycles of the 32.768 kHz oscillator.
package sup_pkg;

    // Reset line phase: HOLD sinks the line, RUN releases it
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } sup_state_e;

    // Watchdog period in cycles for a select code (0:1x, 1:3x, 2/3:6x)
    function automatic int unsigned tmo_cycles(input logic [1:0] sel,
                                               input int unsigned base);
        case (sel)
            2'd0:    return base;
            2'd1:    return 3 * base;
            default: return 6 * base;
        endcase
    endfunction

endpackage

// File: rtl/sup_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for an asynchronous level input.
// Assumes STAGES >= 1; all stages clear to 0 under reset.
module sup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop capture
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the input through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_wdt_timer.sv
`timescale 1ns/1ps
// Watchdog period counter.
// Counts while the line is released (run) and the watchdog is enabled.
// A kick, a disable or the hold phase clears it. expire is a
// combinational flag for the edge at which the period is used up. It
// uses >= so that a select lowered mid-count still expires.
// Assumes kick and tmo_sel are synchronous to clk.
module sup_wdt_timer #(
    parameter int unsigned BASE_CYCLES = 8192,
    parameter int          CNT_W       = $clog2(6 * BASE_CYCLES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       en,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       expire
);
    import sup_pkg::*;

    localparam int unsigned LONG_M1 = 6 * BASE_CYCLES - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit_m1;

    // Last count value allowed for the selected period
    always_comb limit_m1 = CNT_W'(tmo_cycles(sel, BASE_CYCLES) - 1);

    // Period used up on this edge, unless a kick arrives with it
    always_comb expire = run && en && !kick && (cnt >= limit_m1);

    // Advance or clear the period count
    always_ff @(posedge clk) begin
        if (!rst_n)                               cnt <= '0;
        else if (!run || !en || kick || expire)   cnt <= '0;
        else                                      cnt <= cnt + 1'b1;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LONG_M1));

    // R4
    kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kick) |=> (cnt == '0));

    // R5
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: rtl/sup_hold_timer.sv
`timescale 1ns/1ps
// Minimum reset pulse counter.
// Counts during the hold phase while the supply is good. Any cycle with
// the low-voltage flag set restarts it. done flags the edge that
// completes PULSE_CYCLES of good supply.
// Assumes PULSE_CYCLES >= 1.
module sup_hold_timer #(
    parameter int unsigned PULSE_CYCLES = 8192,
    parameter int          PW           = $clog2(PULSE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic lv,
    output logic done
);
    localparam logic [PW-1:0] LAST = PW'(PULSE_CYCLES - 1);

    logic [PW-1:0] cnt;

    // Final good-supply cycle of the hold
    always_comb done = active && !lv && (cnt == LAST);

    // Count good-supply cycles of the hold
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (!active || lv || done)   cnt <= '0;
        else                              cnt <= cnt + 1'b1;
    end

    // R1
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7
    lv_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lv |=> (cnt == '0));
endmodule

// File: rtl/sup_reset_gen.sv
`timescale 1ns/1ps
// Supervisor reset generator: power-on, low-voltage and watchdog reset
// sources merged onto one open-drain, active-low reset drive.
// rst_pull_low = 1 means the pad sinks the reset line.
// Assumes clk is the 32.768 kHz oscillator and rst_n is a synchronous
// power-on reset. low_volt may be asynchronous.
module sup_reset_gen #(
    parameter int unsigned BASE_CYCLES  = 8192,
    parameter int unsigned PULSE_CYCLES = 8192,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick,
    input  logic [1:0] tmo_sel,
    input  logic       wdt_en,
    input  logic       low_volt,
    output logic       rst_pull_low
);
    import sup_pkg::*;

    localparam int WDT_W  = $clog2(6 * BASE_CYCLES);
    localparam int HOLD_W = $clog2(PULSE_CYCLES + 1);

    sup_state_e state;
    logic       lv_s;
    logic       wd_expire;
    logic       hold_done;

    sup_sync #(.STAGES(SYNC_STAGES)) u_lv_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (low_volt),
        .q     (lv_s)
    );

    sup_wdt_timer #(.BASE_CYCLES(BASE_CYCLES), .CNT_W(WDT_W)) u_wdt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_RUN),
        .en     (wdt_en),
        .kick   (kick),
        .sel    (tmo_sel),
        .expire (wd_expire)
    );

    sup_hold_timer #(.PULSE_CYCLES(PULSE_CYCLES), .PW(HOLD_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_HOLD),
        .lv     (lv_s),
        .done   (hold_done)
    );

    // Phase sequencing between hold and run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            case (state)
                ST_HOLD: if (hold_done)          state <= ST_RUN;
                default: if (lv_s || wd_expire)  state <= ST_HOLD;
            endcase
        end
    end

    // Drive the pad whenever the line is held
    assign rst_pull_low = (state == ST_HOLD);

    // R7
    lv_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lv_s |=> rst_pull_low);

    // R5
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !wdt_en && !lv_s) |=> !rst_pull_low);

    // R6
    release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull_low) |-> $past(hold_done));

    // R3
    assert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pull_low) |-> ($past(lv_s) || $past(wd_expire)));
endmodule

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
// Bench for sup_reset_gen with a small base period; every expected edge
// count is computed from the requirements.
module tb_sup_reset_gen;
    localparam int BASE  = 8;
    localparam int PULSE = 6;
    localparam int SYNC  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kick = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic       wdt_en = 1'b1;
    logic       low_volt = 1'b0;
    logic       rst_pull_low;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sup_reset_gen #(.BASE_CYCLES(BASE), .PULSE_CYCLES(PULSE),
                    .SYNC_STAGES(SYNC)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick         (kick),
        .tmo_sel      (tmo_sel),
        .wdt_en       (wdt_en),
        .low_volt     (low_volt),
        .rst_pull_low (rst_pull_low)
    );

    function automatic int lim(input int s);
        return (s == 0) ? BASE : (s == 1) ? 3 * BASE : 6 * BASE;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic count_until(input logic val, input int maxn, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (rst_pull_low !== val && n < maxn);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        int highs;
        // R1 power-on
        repeat (3) step();
        chk("R1 held in reset", int'(rst_pull_low), 1);
        rst_n = 1'b1;
        count_until(1'b0, 1000, n);
        chk("R1 power-on pulse", n, PULSE);

        // R2 R3 R6 timeout per select code, no kicks
        for (int s = 0; s < 4; s++) begin
            tmo_sel = 2'(s);
            count_until(1'b1, 1000, n);
            chk("R2 R3 timeout", n, lim(s));
            count_until(1'b0, 1000, n);
            chk("R6 watchdog pulse", n, PULSE);
        end

        // R4 every kick offset per select code
        for (int s = 0; s < 4; s++) begin
            for (int k = 1; k < lim(s); k++) begin
                tmo_sel = 2'(s);
                repeat (k - 1) step();
                chk("R4 no early reset", int'(rst_pull_low), 0);
                kick = 1'b1;
                step();
                kick = 1'b0;
                count_until(1'b1, 1000, n);
                chk("R4 timeout after kick", n, lim(s));
                count_until(1'b0, 1000, n);
                chk("R6 pulse after kick run", n, PULSE);
            end
        end

        // R9 kicks during hold do not shorten or stretch it
        tmo_sel = 2'd0;
        count_until(1'b1, 1000, n);
        chk("R3 timeout before hold kicks", n, BASE);
        kick = 1'b1;
        count_until(1'b0, 1000, n);
        kick = 1'b0;
        chk("R9 hold with kicks", n, PULSE);

        // R5 disabled watchdog, then enable per select code
        for (int s = 0; s < 4; s++) begin
            tmo_sel = 2'(s);
            wdt_en = 1'b0;
            highs = 0;
            for (int i = 0; i < 3 * 6 * BASE; i++) begin
                kick = (i % 5 == 0);
                step();
                if (rst_pull_low) highs++;
            end
            kick = 1'b0;
            chk("R5 disabled never resets", highs, 0);
            wdt_en = 1'b1;
            count_until(1'b1, 1000, n);
            chk("R5 period after enable", n, lim(s));
            count_until(1'b0, 1000, n);
            chk("R6 pulse after enable", n, PULSE);
        end

        // R8 select lowered past the new limit
        tmo_sel = 2'd2;
        repeat (30) step();
        chk("R8 long period running", int'(rst_pull_low), 0);
        tmo_sel = 2'd0;
        step();
        chk("R8 immediate expiry", int'(rst_pull_low), 1);
        count_until(1'b0, 1000, n);
        chk("R6 pulse after switch", n, PULSE);

        // R8 select lowered below the new limit
        tmo_sel = 2'd2;
        repeat (3) step();
        tmo_sel = 2'd0;
        count_until(1'b1, 1000, n);
        chk("R8 remaining count", n, BASE - 3);
        count_until(1'b0, 1000, n);
        chk("R6 pulse after short switch", n, PULSE);

        // R7 low voltage while running
        tmo_sel = 2'd2;
        repeat (4) step();
        low_volt = 1'b1;
        count_until(1'b1, 1000, n);
        chk("R7 assert latency", n, SYNC + 1);
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            if (rst_pull_low) highs++;
        end
        chk("R7 held while low", highs, 100);
        low_volt = 1'b0;
        count_until(1'b0, 1000, n);
        chk("R7 release after recovery", n, PULSE + SYNC);

        // R7 one-cycle flag during the power-on hold restarts it
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        step();
        low_volt = 1'b1;
        step();
        low_volt = 1'b0;
        count_until(1'b0, 1000, n);
        chk("R7 glitch restarts hold", n, PULSE + SYNC);

        // R7 low voltage during a watchdog hold
        tmo_sel = 2'd0;
        count_until(1'b1, 1000, n);
        chk("R3 timeout before glitch", n, BASE);
        step();
        low_volt = 1'b1;
        step();
        low_volt = 1'b0;
        count_until(1'b0, 1000, n);
        chk("R7 glitch in watchdog hold", n, PULSE + SYNC);

        summary();
        $finish;
    end
endmodule